// File: doc/BRIEF.md
# Appliance Safety Interlock Controller

This block is the run gate of a food-waste appliance. It decides, on every clock, whether the motor, heater and fan may be powered, and whether the user may be told that the machine is ready. Its inputs are a raw lid switch level, a protective trip line, a water-ingress flag, and two user requests: start and reset. The lid level arrives asynchronously and may chatter when wet. It is synchronised and then has to remain closed for a qualification time before the machine may arm.

A four-state controller (Safe, Armed, Running, Fault-Latched) turns the qualified lid, the trip line and the water flag into enables. A trip latches a fault that only an explicit reset clears. A lid opening or water ingress during a run stops the machine and sends it back to Safe. A new start request is then required after the lid has requalified. A saturating counter of lid transitions is provided for diagnostics, so that droplet-induced chatter can be seen.

Top module: `appl_interlock`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, the controller is in Safe: `motor_en`, `heater_en`, `fan_en`, `ready` and `fault` are 0 and `toggle_cnt` is 0.
- R2: The synchronised lid level must read closed (1) for `DEB_CYC + STAB_CYC` consecutive cycles before arming. A low level in any single cycle restarts that count. With a 2-stage synchroniser, `ready` rises `DEB_CYC + STAB_CYC + 3` rising edges after the raw lid last went high.
- R3: From Armed, a start request (`start_req` = 1 at an edge) enters Running. Running drives `motor_en`, `heater_en` and `fan_en` to 1 and `ready` to 0. A start request in any other state has no effect.
- R4: If the lid opens while Running, the controller returns to Safe, with all enables at 0 three edges after the raw lid falls. It does not run again until the lid has requalified and a new start request arrives.
- R5: `trip` = 1 forces `motor_en`, `heater_en` and `fan_en` to 0 in the same cycle. From any state, the controller enters Fault-Latched at the next edge, and `fault` = 1 there.
- R6: Fault-Latched is left only through `reset_req` = 1 with `trip` = 0 at an edge. The exit goes to Safe, not Armed, so `ready` stays 0 for at least one cycle afterwards.
- R7: `ready` is 1 only in Armed, and only while the synchronised lid is stably closed, `water_flag` is 0 and `trip` is 0.
- R8: While `water_flag` = 1, the controller does not arm. Armed or Running falls back to Safe at the next edge, and start requests are ignored.
- R9: `toggle_cnt` increases by one for each change of the synchronised lid level. It holds at its all-ones value (15 for `CNT_W` = 4) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lid_closed_raw | input | 1 | Asynchronous lid switch level, 1 = closed |
| trip | input | 1 | Protective trip line, 1 = tripped |
| water_flag | input | 1 | Water ingress detected |
| start_req | input | 1 | User start request |
| reset_req | input | 1 | User fault reset request |
| motor_en | output | 1 | Motor drive enable |
| heater_en | output | 1 | Heater enable |
| fan_en | output | 1 | Fan enable |
| ready | output | 1 | Ready indicator |
| fault | output | 1 | Fault indicator |
| toggle_cnt | output | CNT_W | Saturating count of synchronised lid transitions |

## Verification
The embedded properties watch the state rules on every cycle. They check that a trip always lands in Fault-Latched, that Fault-Latched is left only through a reset with trip low and only into Safe, that a lid drop or water stops Running, that Running is entered only from Armed, and that ready never shows with an open synchronised lid. They also check that the toggle counter steps by one and never wraps. The exact arming latency, the restart of qualification at every bounce position, the same-cycle cut of the enables on trip, and the saturation point across a sweep of toggle counts are shown only by the bench scenarios.

// File: rtl/ilk_pkg.sv
// Shared types for the appliance interlock controller.
package ilk_pkg;
    typedef enum logic [1:0] {
        ST_SAFE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } ilk_state_e;
endpackage

// File: rtl/ilk_sync.sv
// ilk_sync: multi-stage flop synchroniser for one asynchronous level.
// Assumes: STAGES >= 2; resets to 0 (lid treated as open after reset).
module ilk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Capture the asynchronous level into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) ff[0] <= 1'b0;
                    else        ff[0] <= d;
                end
            end else begin : g_next
                // Pass the level one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) ff[gi] <= 1'b0;
                    else        ff[gi] <= ff[gi-1];
                end
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/ilk_qualify.sv
// ilk_qualify: counts consecutive closed cycles of the synchronised lid;
// reports stable only once QUAL_CYC cycles have been seen and the lid is
// still closed. Any open cycle restarts the count.
// Assumes: lid is already synchronous to clk.
module ilk_qualify #(
    parameter int QUAL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lid,
    output logic stable
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(QUAL_CYC);

    logic [CW-1:0] cnt;

    // Count closed cycles up to FULL; clear on any open cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!lid)        cnt <= '0;
        else if (cnt != FULL) cnt <= cnt + 1'b1;
    end

    assign stable = lid && (cnt == FULL);

    // R2: stability implies the lid was also closed in the previous cycle.
    a_r2_stable_history: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> $past(lid));
    // R2: an open cycle always restarts qualification.
    a_r2_open_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !lid |=> !stable);
endmodule

// File: rtl/ilk_toggle.sv
// ilk_toggle: saturating counter of level changes on the synchronised lid.
// Assumes: lid is synchronous to clk; the reference level after reset is 0.
module ilk_toggle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lid,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAX = '1;

    logic prev;

    // Remember last level so a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lid;
    end

    // Count changes, holding at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if ((lid != prev) && cnt != MAX) cnt <= cnt + 1'b1;
    end

    // R9: the count never wraps from its top value.
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX) |=> (cnt == MAX));
    // R9: each change of the count is a step of exactly one.
    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/appl_interlock.sv
// appl_interlock: run gate for the appliance. Synchronises and qualifies the
// lid level, runs the Safe/Armed/Running/Fault-Latched controller, and
// derives the enables and indicators from it.
// Assumes: trip, water_flag, start_req and reset_req are synchronous to clk.
module appl_interlock
    import ilk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 16,
    parameter int STAB_CYC    = 64,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lid_closed_raw,
    input  logic             trip,
    input  logic             water_flag,
    input  logic             start_req,
    input  logic             reset_req,
    output logic             motor_en,
    output logic             heater_en,
    output logic             fan_en,
    output logic             ready,
    output logic             fault,
    output logic [CNT_W-1:0] toggle_cnt
);
    localparam int QUAL_CYC = DEB_CYC + STAB_CYC;

    logic       lid_sync;
    logic       lid_ok;
    ilk_state_e state, state_nx;

    ilk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(lid_closed_raw), .q(lid_sync)
    );

    ilk_qualify #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .lid(lid_sync), .stable(lid_ok)
    );

    ilk_toggle #(.CNT_W(CNT_W)) u_tog (
        .clk(clk), .rst_n(rst_n), .lid(lid_sync), .cnt(toggle_cnt)
    );

    // Next-state choice; trip overrides everything else.
    always_comb begin
        state_nx = state;
        if (trip) begin
            state_nx = ST_FAULT;
        end else begin
            unique case (state)
                ST_SAFE:  if (lid_ok && !water_flag) state_nx = ST_ARMED;
                ST_ARMED: if (!lid_ok || water_flag) state_nx = ST_SAFE;
                          else if (start_req)        state_nx = ST_RUN;
                ST_RUN:   if (!lid_ok || water_flag) state_nx = ST_SAFE;
                ST_FAULT: if (reset_req)             state_nx = ST_SAFE;
                default:                             state_nx = ST_SAFE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SAFE;
        else        state <= state_nx;
    end

    // Enables and indicators; trip and interlocks cut them in the same cycle.
    always_comb begin
        motor_en  = (state == ST_RUN) && !trip;
        heater_en = (state == ST_RUN) && !trip;
        fan_en    = (state == ST_RUN) && !trip;
        ready     = (state == ST_ARMED) && lid_ok && !water_flag && !trip;
        fault     = (state == ST_FAULT);
    end

    // R5: a trip always lands in Fault-Latched.
    a_r5_trip_latch: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state == ST_FAULT));
    // R6: Fault-Latched is left only by a reset with trip low, into Safe.
    a_r6_exit_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> (state == ST_FAULT) ||
            ($past(reset_req && !trip) && state == ST_SAFE));
    // R4: losing the lid while running stops the machine into Safe.
    a_r4_lid_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !lid_ok && !trip) |=> (state == ST_SAFE));
    // R8: water keeps the controller out of Armed and Running.
    a_r8_water_block: assert property (@(posedge clk) disable iff (!rst_n)
        (water_flag && !trip) |=> (state == ST_SAFE || state == ST_FAULT));
    // R3: Running is entered only from Armed.
    a_r3_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $past(state == ST_RUN || state == ST_ARMED));
    // R2: arming requires the qualified lid in the cycle before.
    a_r2_arm_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> $past(lid_ok));
    // R7: ready is never shown with the synchronised lid open.
    a_r7_ready_lid: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> lid_sync);
endmodule

// File: tb/sim_appl_interlock.sv
module sim_appl_interlock;
    localparam int DEB  = 3;
    localparam int STAB = 5;
    localparam int Q    = DEB + STAB;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lid_closed_raw = 1'b0, trip = 1'b0, water_flag = 1'b0;
    logic start_req = 1'b0, reset_req = 1'b0;
    logic motor_en, heater_en, fan_en, ready, fault;
    logic [CW-1:0] toggle_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    appl_interlock #(.SYNC_STAGES(2), .DEB_CYC(DEB), .STAB_CYC(STAB), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .lid_closed_raw(lid_closed_raw), .trip(trip),
        .water_flag(water_flag), .start_req(start_req), .reset_req(reset_req),
        .motor_en(motor_en), .heater_en(heater_en), .fan_en(fan_en),
        .ready(ready), .fault(fault), .toggle_cnt(toggle_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; lid_closed_raw = 1'b0; trip = 1'b0; water_flag = 1'b0;
        start_req = 1'b0; reset_req = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic edges_to_ready(output int n);
        n = 0;
        while (!ready && n < 60) begin
            step(1);
            n++;
        end
    endtask

    task automatic arm_and_run();
        int n;
        lid_closed_raw = 1'b1;
        edges_to_ready(n);
        start_req = 1'b1; step(1); start_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        step(1);
        // R1: reset state
        chk({motor_en, heater_en, fan_en, ready, fault} == 5'b0, "R1 outputs in reset",
            {motor_en, heater_en, fan_en, ready, fault}, 0);
        do_reset();
        step(1);
        chk({motor_en, heater_en, fan_en, ready, fault} == 5'b0, "R1 outputs after reset",
            {motor_en, heater_en, fan_en, ready, fault}, 0);
        chk(toggle_cnt == 0, "R1 toggle count", toggle_cnt, 0);

        // R2: clean arming latency
        lid_closed_raw = 1'b1;
        edges_to_ready(n);
        chk(n == Q + 3, "R2 arming latency", n, Q + 3);

        // R2/R9: bounce at every position restarts qualification
        for (int g = 1; g <= Q; g++) begin
            do_reset();
            lid_closed_raw = 1'b1; step(g);
            lid_closed_raw = 1'b0; step(1);
            lid_closed_raw = 1'b1;
            edges_to_ready(n);
            chk(n == Q + 3, $sformatf("R2 bounce at %0d", g), n, Q + 3);
            chk(toggle_cnt == 3, "R9 bounce toggles", toggle_cnt, 3);
        end

        // R3: start ignored while Safe
        do_reset();
        start_req = 1'b1; step(3); start_req = 1'b0;
        chk(motor_en == 1'b0, "R3 start ignored in Safe", motor_en, 0);
        // R3: run from Armed
        arm_and_run();
        chk({motor_en, heater_en, fan_en} == 3'b111, "R3 run enables",
            {motor_en, heater_en, fan_en}, 7);
        chk(ready == 1'b0, "R3 ready off in run", ready, 0);

        // R4: lid open during run
        lid_closed_raw = 1'b0; step(2);
        chk(motor_en == 1'b1, "R4 motor before sync delay", motor_en, 1);
        step(1);
        chk({motor_en, heater_en, fan_en, ready} == 4'b0, "R4 stop on lid open",
            {motor_en, heater_en, fan_en, ready}, 0);
        lid_closed_raw = 1'b1;
        edges_to_ready(n);
        chk(n == Q + 3, "R4 requalify before ready", n, Q + 3);
        step(3);
        chk(motor_en == 1'b0, "R4 no restart without start", motor_en, 0);

        // R5: trip from Running cuts enables in the same cycle
        start_req = 1'b1; step(1); start_req = 1'b0;
        trip = 1'b1; #1;
        chk({motor_en, heater_en, fan_en} == 3'b0, "R5 same-cycle cut",
            {motor_en, heater_en, fan_en}, 0);
        step(1);
        chk(fault == 1'b1, "R5 fault from Running", fault, 1);
        // R6: reset ignored while trip high, and without reset
        reset_req = 1'b1; step(2); reset_req = 1'b0;
        chk(fault == 1'b1, "R6 reset blocked by trip", fault, 1);
        trip = 1'b0; step(3);
        chk(fault == 1'b1, "R6 hold without reset", fault, 1);
        reset_req = 1'b1; step(1); reset_req = 1'b0;
        chk(fault == 1'b0 && ready == 1'b0, "R6 exit to Safe", {fault, ready}, 0);
        step(1);
        chk(ready == 1'b1, "R6 rearm after Safe", ready, 1);
        // R5: trip from Armed and from Safe
        trip = 1'b1; step(1); trip = 1'b0;
        chk(fault == 1'b1 && ready == 1'b0, "R5 fault from Armed", {fault, ready}, 2);
        do_reset();
        trip = 1'b1; step(1); trip = 1'b0;
        chk(fault == 1'b1, "R5 fault from Safe", fault, 1);

        // R7/R8: water blocks arming and running
        do_reset();
        lid_closed_raw = 1'b1;
        edges_to_ready(n);
        water_flag = 1'b1; #1;
        chk(ready == 1'b0, "R7 ready drops with water", ready, 0);
        start_req = 1'b1; step(Q + 4); start_req = 1'b0;
        chk(motor_en == 1'b0 && ready == 1'b0, "R8 no arm or run under water",
            {motor_en, ready}, 0);
        water_flag = 1'b0; step(1);
        chk(ready == 1'b1, "R8 arm after water clears", ready, 1);
        start_req = 1'b1; step(1); start_req = 1'b0;
        water_flag = 1'b1; step(1);
        chk(motor_en == 1'b0, "R8 water stops run", motor_en, 0);
        water_flag = 1'b0;

        // R9/R7: toggle sweep with saturation; ready never shown while chattering
        for (int t = 0; t <= CMAX + 5; t++) begin
            do_reset();
            for (int i = 0; i < t; i++) begin
                lid_closed_raw = ~lid_closed_raw;
                step(3);
                chk(ready == 1'b0, "R7 no ready during chatter", ready, 0);
            end
            step(3);
            chk(toggle_cnt == ((t > CMAX) ? CMAX : t), $sformatf("R9 toggles=%0d", t),
                toggle_cnt, (t > CMAX) ? CMAX : t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule